// File: doc/BRIEF.md
# Sector Bit-Error Corrector

This block repairs one 512-byte data sector after an external decoder has located the bad bits. The decoder returns its results as three 32-bit words, one byte carried inside a status word, and a 4-bit error count in that same status word. On a start pulse the block captures these values and rebuilds one 104-bit location word from them. It then treats that word as eight packed 13-bit bit offsets. For each offset in use, it corrects the stored offset, checks that the offset lies inside the sector, and inverts the addressed bit. The inversion is a read-modify-write over a byte-wide port to a sector buffer with one cycle of read latency.

At the end of a sequence the block gives a one-cycle done pulse. With it comes the number of bits it actually inverted, or an uncorrectable flag when the count field is all ones. A host reads the sector into the buffer, pulses start with the decoder results and waits for done. It then either keeps the repaired sector or treats the sector as lost.

Top module: `sector_bitfix`

## Requirements
- R1: After a synchronous active-low reset, busy, done, buf_rd_en and buf_wr_en are low, and fix_count and uncorrectable are zero.
- R2: The 104-bit location word is {status[23:16], res2, res1, res0}. Packed offset k (k = 0..7) is bits 13k+12 down to 13k of that word.
- R3: Each packed offset is XORed with 3 (its two lowest bits inverted) before it is used as a bit address.
- R4: Bit address a lies in byte a[11:3] and bit a[2:0]. The block reads that byte in one cycle. In the next cycle it writes back the returned byte XOR (1 << a[2:0]) to the same address. Reads and writes never occur in the same cycle.
- R5: The error count is status[13:10]. Offsets are used in index order 0 to L-1, where L is that count limited to 8.
- R6: A count of 15 marks the sector uncorrectable. No buffer access takes place. Done rises in the cycle after start, with uncorrectable = 1 and fix_count = 0.
- R7: An adjusted offset of 4096 or more makes no buffer access and is not counted. Processing continues with the next offset.
- R8: Done is a single-cycle pulse that arrives 2L+1 cycles after the start edge (1 cycle when L = 0). Busy is high from the cycle after start through the done cycle.
- R9: A start pulse while busy is ignored and does not disturb the running sequence.
- R10: fix_count equals the number of bits inverted. It holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a correction pass (ignored while busy) |
| res0 | input | 32 | Location result word, bytes 0-3 |
| res1 | input | 32 | Location result word, bytes 4-7 |
| res2 | input | 32 | Location result word, bytes 8-11 |
| status | input | 32 | Bits 23:16 give byte 12, bits 13:10 give the error count |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fix_count | output | 4 | Number of bits inverted |
| uncorrectable | output | 1 | Sector flagged as beyond repair |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read request (data returns next cycle) |
| buf_rd_data | input | 8 | Buffer read data |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_data | output | 8 | Buffer write data |

## Verification
A wrong offset index or a wrong unpacking shift shows up as a flipped bit in the wrong byte. The bench finds it when it compares the whole buffer at the done pulse, at most 17 cycles after start. A sequencer that stops early or overruns changes the done latency and fix_count in that same pass. A missing XOR-with-3 or a missing range test inverts a neighbouring bit or touches a byte that should stay clean. The bench catches both through its write counter and the buffer compare. Because a start while busy is dropped, a latch taken during a run would corrupt the final repair of that same pass.

// File: rtl/bitfix_pkg.sv
// Shared constants and types for the sector bit corrector.
// Assumes the status word carries the error count at bits 13:10 and the
// top byte of the location word at bits 23:16.
package bitfix_pkg;
    localparam int OFF_W        = 13;  // width of one packed offset
    localparam int MAX_ERR      = 8;   // offsets per location word
    localparam int CNT_W        = 4;   // width of the error-count field
    localparam int STS_CNT_LSB  = 10;  // error count position in status
    localparam int STS_BYTE_LSB = 16;  // location byte 12 position in status
    localparam int LOC_W        = OFF_W * MAX_ERR;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } fix_state_t;
endpackage

// File: rtl/bitfix_unpack.sv
// Selects one packed offset from the captured location word, applies the
// low-bit inversion and reports whether it falls inside the sector.
// Assumes idx is below MAX_ERR.
module bitfix_unpack #(
    parameter int OFF_W        = 13,
    parameter int MAX_ERR      = 8,
    parameter int SECTOR_BYTES = 512,
    parameter int IDX_W        = $clog2(MAX_ERR),
    parameter int BADDR_W      = $clog2(SECTOR_BYTES) + 3
) (
    input  logic [OFF_W*MAX_ERR-1:0] loc_word,
    input  logic [IDX_W-1:0]         idx,
    output logic [BADDR_W-1:0]       bit_addr,
    output logic                     in_range
);
    localparam logic [OFF_W:0] BIT_LIMIT = (OFF_W+1)'(SECTOR_BYTES * 8);

    logic [OFF_W-1:0] adj [MAX_ERR];
    logic [OFF_W-1:0] sel;

    // one adjusted offset per packed slot
    for (genvar g = 0; g < MAX_ERR; g++) begin : g_slot
        assign adj[g] = loc_word[g*OFF_W +: OFF_W] ^ OFF_W'(3);
    end

    // pick the active slot and test its range
    always_comb begin
        sel      = adj[idx];
        in_range = {1'b0, sel} < BIT_LIMIT;
        bit_addr = sel[BADDR_W-1:0];
    end
endmodule

// File: rtl/bitfix_flip.sv
// Datapath for one bit inversion: splits a bit address into byte address
// and bit mask and forms the write-back byte from the read byte.
module bitfix_flip #(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W+2:0] bit_addr,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        wr_data
);
    // address split and masked inversion
    always_comb begin
        byte_addr = bit_addr[ADDR_W+2:3];
        wr_data   = rd_data ^ (8'h01 << bit_addr[2:0]);
    end
endmodule

// File: rtl/bitfix_seq.sv
// Sequencer: accepts a start in idle, walks offsets 0..L-1 at two cycles
// each (read, then write), counts applied flips and signals completion.
// Assumes the buffer returns read data one cycle after the read request.
module bitfix_seq
    import bitfix_pkg::*;
#(
    parameter int MAX_ERR = 8,
    parameter int CNT_W   = 4,
    parameter int IDX_W   = $clog2(MAX_ERR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] err_cnt,
    input  logic             in_range,
    output logic             accept,
    output logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic             done,
    output logic             rd_en,
    output logic             wr_en,
    output logic [CNT_W-1:0] fix_count,
    output logic             uncorr
);
    localparam logic [CNT_W-1:0] CAP     = CNT_W'(MAX_ERR);
    localparam logic [CNT_W-1:0] ALL_ONE = '1;

    fix_state_t       state;
    logic [CNT_W-1:0] lim;
    logic             last;

    // decode of state into strobes
    always_comb begin
        accept = start && (state == ST_IDLE);
        busy   = (state != ST_IDLE);
        done   = (state == ST_FINISH);
        rd_en  = (state == ST_READ)  && in_range;
        wr_en  = (state == ST_WRITE) && in_range;
        last   = (CNT_W'(idx) + CNT_W'(1)) == lim;
    end

    // state, index, limit and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            lim       <= '0;
            fix_count <= '0;
            uncorr    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        idx       <= '0;
                        fix_count <= '0;
                        lim       <= (err_cnt > CAP) ? CAP : err_cnt;
                        uncorr    <= (err_cnt == ALL_ONE);
                        if (err_cnt == ALL_ONE || err_cnt == '0)
                            state <= ST_FINISH;
                        else
                            state <= ST_READ;
                    end
                end
                ST_READ: state <= ST_WRITE;
                ST_WRITE: begin
                    if (in_range)
                        fix_count <= fix_count + CNT_W'(1);
                    if (last) begin
                        state <= ST_FINISH;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        state <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sector_bitfix.sv
// Top level: captures the decoder results on an accepted start, rebuilds
// the 104-bit location word and applies the located bit flips to an
// external sector buffer via read-modify-write.
// Assumes a byte-wide buffer with one cycle of read latency.
module sector_bitfix
    import bitfix_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_W       = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       res0,
    input  logic [31:0]       res1,
    input  logic [31:0]       res2,
    input  logic [31:0]       status,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  fix_count,
    output logic              uncorrectable,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd_en,
    input  logic [7:0]        buf_rd_data,
    output logic              buf_wr_en,
    output logic [7:0]        buf_wr_data
);
    localparam int IDX_W   = $clog2(MAX_ERR);
    localparam int BADDR_W = ADDR_W + 3;

    logic [LOC_W-1:0]   loc_q;
    logic               accept;
    logic [IDX_W-1:0]   idx;
    logic [BADDR_W-1:0] bit_addr;
    logic               in_range;
    logic [17:0]        sts_unused_bits;

    assign sts_unused_bits = {status[31:24], status[15:14], status[9:0]};

    // capture the packed location word on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)
            loc_q <= '0;
        else if (accept)
            loc_q <= {status[STS_BYTE_LSB +: 8], res2, res1, res0};
    end

    bitfix_seq #(
        .MAX_ERR (MAX_ERR),
        .CNT_W   (CNT_W),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .err_cnt   (status[STS_CNT_LSB +: CNT_W]),
        .in_range  (in_range),
        .accept    (accept),
        .idx       (idx),
        .busy      (busy),
        .done      (done),
        .rd_en     (buf_rd_en),
        .wr_en     (buf_wr_en),
        .fix_count (fix_count),
        .uncorr    (uncorrectable)
    );

    bitfix_unpack #(
        .OFF_W        (OFF_W),
        .MAX_ERR      (MAX_ERR),
        .SECTOR_BYTES (SECTOR_BYTES),
        .IDX_W        (IDX_W),
        .BADDR_W      (BADDR_W)
    ) u_unpack (
        .loc_word (loc_q),
        .idx      (idx),
        .bit_addr (bit_addr),
        .in_range (in_range)
    );

    bitfix_flip #(
        .ADDR_W (ADDR_W)
    ) u_flip (
        .bit_addr  (bit_addr),
        .rd_data   (buf_rd_data),
        .byte_addr (buf_addr),
        .wr_data   (buf_wr_data)
    );
endmodule

// File: rtl/bitfix_chk.sv
// Property checker for sector_bitfix, attached by bind below.
// Observes only top-level ports.
module bitfix_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [3:0]        err_field,
    input logic              busy,
    input logic              done,
    input logic [3:0]        fix_count,
    input logic              uncorrectable,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] buf_addr
);
    // a write always follows a read of the same byte
    assert_rmw_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(rd_en) && $past(buf_addr) == buf_addr));

    // reads and writes are exclusive
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    // idle means no buffer traffic and no done
    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en && !done));

    // busy persists until done
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // all-ones count finishes at once with the flag set
    assert_uncorr_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && err_field == 4'hF) |=>
            (done && uncorrectable && fix_count == 4'd0));

    // corrected count never exceeds the per-sector cap
    assert_count_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fix_count <= 4'd8));
endmodule

bind sector_bitfix bitfix_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .err_field     (status[13:10]),
    .busy          (busy),
    .done          (done),
    .fix_count     (fix_count),
    .uncorrectable (uncorrectable),
    .rd_en         (buf_rd_en),
    .wr_en         (buf_wr_en),
    .buf_addr      (buf_addr)
);

// File: tb/sim_sector_bitfix.sv
module sim_sector_bitfix;
    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] res0 = '0, res1 = '0, res2 = '0, status = '0;
    logic        busy, done, uncorrectable, buf_rd_en, buf_wr_en;
    logic [3:0]  fix_count;
    logic [8:0]  buf_addr;
    logic [7:0]  buf_rd_data, buf_wr_data;

    logic [7:0]  mem  [NBYTES];
    logic [7:0]  gold [NBYTES];
    int          wr_seen = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_bitfix u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .res0(res0), .res1(res1), .res2(res2), .status(status),
        .busy(busy), .done(done), .fix_count(fix_count),
        .uncorrectable(uncorrectable), .buf_addr(buf_addr),
        .buf_rd_en(buf_rd_en), .buf_rd_data(buf_rd_data),
        .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data)
    );

    // sector buffer model: one cycle read latency, pattern on reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= 8'(i * 37 + 5);
            buf_rd_data <= '0;
        end else begin
            if (buf_rd_en) buf_rd_data <= mem[buf_addr];
            if (buf_wr_en) begin
                mem[buf_addr] <= buf_wr_data;
                wr_seen <= wr_seen + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // one correction pass against the bench model
    task automatic run_case(input logic [103:0] w, input logic [3:0] cnt,
                            input bit inject, input string tag);
        int lim, exp_fix, lat, wr0, bad;
        bit exp_unc;
        logic [12:0] a;
        exp_unc = (cnt == 4'hF);
        lim     = exp_unc ? 0 : ((cnt > 8) ? 8 : int'(cnt));
        exp_fix = 0;
        // model: R2 unpack, R3 xor, R4 byte/bit split, R5 order, R7 range
        for (int i = 0; i < lim; i++) begin
            a = w[13*i +: 13] ^ 13'd3;
            if (a < 13'd4096) begin
                gold[a[11:3]] = gold[a[11:3]] ^ (8'h01 << a[2:0]);
                exp_fix++;
            end
        end
        wr0 = wr_seen;
        @(negedge clk);
        res0   = w[31:0];
        res1   = w[63:32];
        res2   = w[95:64];
        status = {$urandom_range(255,0), w[103:96], 2'($urandom), cnt, 10'($urandom)};
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            if (inject && lat == 1) begin
                // R9: start with other data while busy
                res0 = $urandom; res1 = $urandom; res2 = $urandom;
                status = $urandom;
                start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        check(done === 1'b1, "R8", {tag, " done seen"}, done, 1);
        check(lat == 2*lim + 1, "R8", {tag, " latency"}, lat, 2*lim + 1);
        check(fix_count == 4'(exp_fix), "R10", {tag, " fix_count"}, fix_count, exp_fix);
        check(uncorrectable == exp_unc, "R6", {tag, " uncorrectable"}, uncorrectable, exp_unc);
        check(busy === 1'b1, "R8", {tag, " busy at done"}, busy, 1);
        check(wr_seen - wr0 == exp_fix, "R7", {tag, " write count"}, wr_seen - wr0, exp_fix);
        bad = 0;
        for (int i = 0; i < NBYTES; i++) if (mem[i] !== gold[i]) bad++;
        check(bad == 0, "R4", {tag, " sector bytes wrong"}, bad, 0);
        @(negedge clk);
        check(done === 1'b0, "R8", {tag, " done single pulse"}, done, 0);
        check(fix_count == 4'(exp_fix), "R10", {tag, " fix_count held"}, fix_count, exp_fix);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [103:0] w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NBYTES; i++) gold[i] = 8'(i * 37 + 5);
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        check(!buf_rd_en && !buf_wr_en, "R1", "buffer strobes after reset",
              {buf_rd_en, buf_wr_en}, 0);
        check(fix_count == 0 && !uncorrectable, "R1", "results after reset",
              {uncorrectable, fix_count}, 0);

        // R3: raw 0 lands on byte 0 bit 3
        run_case({91'd0, 13'd0}, 4'd1, 1'b0, "R3 single");
        // R2: all eight slots, top slot in status byte, last bit of sector
        w = {13'd4092, 13'd17, 13'd1000, 13'd2049, 13'd300, 13'd77, 13'd4000, 13'd8};
        run_case(w, 4'd8, 1'b0, "R2 eight slots");
        // R7: out-of-range offsets mixed with valid ones
        w = {13'd5, 13'd5, 13'd5, 13'd5, 13'd8191, 13'd100, 13'd4096, 13'd44};
        run_case(w, 4'd4, 1'b0, "R7 range");
        // R5: zero count, no change
        run_case(w, 4'd0, 1'b0, "R5 zero");
        // R6: uncorrectable with valid offsets present
        w = {13'd1, 13'd2, 13'd3, 13'd4, 13'd5, 13'd6, 13'd7, 13'd9};
        run_case(w, 4'hF, 1'b0, "R6 uncorrectable");
        // R5: count above cap is limited to eight
        run_case(w, 4'd12, 1'b0, "R5 clamp");
        // R10: repeated offset cancels but both count
        run_case({78'd0, 13'd222, 13'd222}, 4'd2, 1'b0, "R10 repeat");
        // R9: start while busy ignored
        w = {13'd60, 13'd61, 13'd62, 13'd63, 13'd64, 13'd65, 13'd66, 13'd67};
        run_case(w, 4'd6, 1'b1, "R9 busy start");

        for (int k = 0; k < 40; k++) begin
            logic [3:0] c;
            w = {$urandom, $urandom, $urandom, 8'($urandom)};
            c = 4'($urandom_range(15, 0));
            run_case(w, c, k[0] && c >= 2 && c != 4'hF, "R5 random");
        end
        finish_run();
    end
endmodule